// File: doc/BRIEF.md
# Rotational Position and Index Timer

This block stands in for the spinning surface of a disk with one head per track. A word-position counter steps through the 2048 word slots of a track, moving one slot every programmable number of clock cycles. From that position it derives an index (photocell) status near the start of each revolution and a flag that shows when the head sits over a chosen target word.

A transfer engine issues a start strobe together with a target word. The block then waits the forward modular distance to that word and emits a single-cycle go pulse when the word arrives. Software can also arm a once-per-revolution index interrupt. That interrupt stays raised until a status-clear acknowledge arrives, and it is cancelled whenever the enable is dropped.

Top module: `rot_position_timer`

## Requirements
- R1: While reset is active and after its release, the position reads 0, go and the index interrupt are low, and the photocell status is high.
- R2: The position advances by one after every P clock cycles, where P is the inter-word period, and wraps from 2047 to 0. A period of 0 acts as 1. Lowering P below the cycles already spent in the current word ends that word at the next edge.
- R3: The photocell status is high exactly while the position is 0 to 5.
- R4: The match flag is high exactly while the target input equals the position, with no added latency.
- R5: A start strobe latches the target. Go pulses for one cycle in the first cycle in which the position equals the latched target. The position that results from the strobe's own clock edge counts, so an equal position gives go on the next cycle. Later changes of the target input do not alter the pending transfer.
- R6: A start strobe that arrives while a transfer is pending replaces the pending target.
- R7: With the index enable high, the index interrupt rises in the cycle after the position wraps from 2047 to 0, once per revolution.
- R8: A raised index interrupt stays high until an acknowledge cycle clears it. When a wrap and an acknowledge fall in the same cycle, the interrupt is set.
- R9: With the index enable low, the index interrupt is low from the next cycle on, and wraps do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_i | input | 24 | Clock cycles per word time |
| target_i | input | 11 | Target word address |
| start_i | input | 1 | One-cycle start strobe |
| index_en_i | input | 1 | Index interrupt enable |
| index_ack_i | input | 1 | Status-clear acknowledge for the index interrupt |
| pos_o | output | 11 | Current word position |
| photocell_o | output | 1 | Index status, high for positions 0 to 5 |
| match_o | output | 1 | Target equals position |
| go_o | output | 1 | One-cycle transfer start pulse |
| index_irq_o | output | 1 | Held index interrupt |

## Verification
The bench aims at a start strobe whose target equals the position that will exist after the strobe edge. A design that computes the distance from the stale position would wait a full extra revolution, or would fire one word early. It also issues a strobe one word behind the head, which must wait 2047 words. A design that is off by one in its countdown lands on the wrong word.

Other cases cover period changes mid-word and a period of zero; a design that compares for equality against the period would stall or run for 2^24 cycles. Further cases cover an acknowledge that coincides with a wrap, where a design with the wrong priority loses an index event. Re-arming while a transfer is pending is also checked; a design that ignores the new target fires at the old word.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int unsigned WORD_W     = 11;
  localparam int unsigned PERIOD_W   = 24;
  localparam int unsigned INDEX_SPAN = 6;
endpackage

// File: rtl/rpt_prescaler.sv
module rpt_prescaler #(
  parameter int unsigned PERIOD_W = rpt_pkg::PERIOD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt_q, cnt_d, last_w;

  always_comb begin
    last_w = (period_i == '0) ? '0 : period_i - ONE;
    tick_o = (cnt_q >= last_w);
    cnt_d  = tick_o ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: after a tick the word-time count restarts from zero
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rpt_position.sv
module rpt_position #(
  parameter int unsigned WORD_W     = rpt_pkg::WORD_W,
  parameter int unsigned INDEX_SPAN = rpt_pkg::INDEX_SPAN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] target_i,
  output logic [WORD_W-1:0] pos_o,
  output logic [WORD_W-1:0] pos_next_o,
  output logic              wrap_o,
  output logic              photocell_o,
  output logic              match_o
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(1);
  localparam logic [WORD_W-1:0] SPAN = WORD_W'(INDEX_SPAN);
  localparam logic [WORD_W-1:0] LAST = '1;

  logic [WORD_W-1:0] pos_q;

  always_comb begin
    pos_next_o  = tick_i ? pos_q + STEP : pos_q;
    wrap_o      = tick_i && (pos_q == LAST);
    photocell_o = (pos_q < SPAN);
    match_o     = (target_i == pos_q);
    pos_o       = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (tick_i) pos_q <= pos_q + STEP;
  end

  // R2: position only moves on a word tick, and then by exactly one
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pos_q));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (pos_q == $past(pos_q) + STEP));
  // R3: the index status can only turn on at word zero
  a_r3_index_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(photocell_o) |-> (pos_q == '0));
endmodule

// File: rtl/rpt_start_delay.sv
module rpt_start_delay #(
  parameter int unsigned WORD_W = rpt_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] target_i,
  input  logic [WORD_W-1:0] pos_i,
  input  logic [WORD_W-1:0] pos_next_i,
  output logic              go_o
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  logic              armed_q, armed_d;
  logic [WORD_W-1:0] remain_q, remain_d;
  logic [WORD_W-1:0] tgt_q, tgt_d;
  logic              go_q, go_d;
  logic [WORD_W-1:0] dist_w;

  always_comb begin
    dist_w   = target_i - pos_next_i;
    armed_d  = armed_q;
    remain_d = remain_q;
    tgt_d    = tgt_q;
    go_d     = 1'b0;
    if (start_i) begin
      tgt_d = target_i;
      if (dist_w == '0) begin
        go_d    = 1'b1;
        armed_d = 1'b0;
      end else begin
        armed_d  = 1'b1;
        remain_d = dist_w;
      end
    end else if (armed_q && tick_i) begin
      if (remain_q == ONE) begin
        go_d    = 1'b1;
        armed_d = 1'b0;
      end else begin
        remain_d = remain_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      remain_q <= '0;
      tgt_q    <= '0;
      go_q     <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      remain_q <= remain_d;
      tgt_q    <= tgt_d;
      go_q     <= go_d;
    end
  end

  assign go_o = go_q;

  // R5: the go pulse always coincides with the head over the latched word
  a_r5_go_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> (pos_i == tgt_q));
  // R5: nothing pending and no strobe means no go
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start_i) |=> !go_q);
endmodule

// File: rtl/rpt_index_irq.sv
module rpt_index_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic enable_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (!enable_i)   irq_d = 1'b0;
    else if (wrap_i) irq_d = 1'b1;
    else if (ack_i)  irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R9: a dropped enable cancels the interrupt
  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !irq_q);
  // R8: without an acknowledge or cancel a raised interrupt persists
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && enable_i && !ack_i) |=> irq_q);
endmodule

// File: rtl/rot_position_timer.sv
module rot_position_timer #(
  parameter int unsigned WORD_W     = rpt_pkg::WORD_W,
  parameter int unsigned PERIOD_W   = rpt_pkg::PERIOD_W,
  parameter int unsigned INDEX_SPAN = rpt_pkg::INDEX_SPAN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [WORD_W-1:0]   target_i,
  input  logic                start_i,
  input  logic                index_en_i,
  input  logic                index_ack_i,
  output logic [WORD_W-1:0]   pos_o,
  output logic                photocell_o,
  output logic                match_o,
  output logic                go_o,
  output logic                index_irq_o
);
  logic              rst_s1_q, rst_s2_q;
  logic              tick_w, wrap_w;
  logic [WORD_W-1:0] pos_w, pos_next_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  rpt_prescaler #(.PERIOD_W(PERIOD_W)) u_presc (
    .clk(clk), .rst_n(rst_s2_q), .period_i(period_i), .tick_o(tick_w));

  rpt_position #(.WORD_W(WORD_W), .INDEX_SPAN(INDEX_SPAN)) u_pos (
    .clk(clk), .rst_n(rst_s2_q), .tick_i(tick_w), .target_i(target_i),
    .pos_o(pos_w), .pos_next_o(pos_next_w), .wrap_o(wrap_w),
    .photocell_o(photocell_o), .match_o(match_o));

  rpt_start_delay #(.WORD_W(WORD_W)) u_delay (
    .clk(clk), .rst_n(rst_s2_q), .tick_i(tick_w), .start_i(start_i),
    .target_i(target_i), .pos_i(pos_w), .pos_next_i(pos_next_w), .go_o(go_o));

  rpt_index_irq u_irq (
    .clk(clk), .rst_n(rst_s2_q), .wrap_i(wrap_w), .enable_i(index_en_i),
    .ack_i(index_ack_i), .irq_o(index_irq_o));

  assign pos_o = pos_w;

  // R7: the index interrupt can only rise just after the wrap to word zero
  a_r7_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $rose(index_irq_o) |-> (pos_o == '0));
endmodule

// File: tb/rot_position_timer_test.sv
module rot_position_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] period = 24'd1;
  logic [10:0] target = '0;
  logic        start = 1'b0;
  logic        pcie = 1'b0;
  logic        ack = 1'b0;
  logic [10:0] pos_o;
  logic        photocell_o, match_o, go_o, index_irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  int mcnt, mpos, mtgt;
  bit marmed, mgo, mirq, ms1, ms2;

  always #5 clk = ~clk;

  rot_position_timer uut (
    .clk(clk), .rst_n(rst_n), .period_i(period), .target_i(target),
    .start_i(start), .index_en_i(pcie), .index_ack_i(ack),
    .pos_o(pos_o), .photocell_o(photocell_o), .match_o(match_o),
    .go_o(go_o), .index_irq_o(index_irq_o));

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    mcnt = 0; mpos = 0; mtgt = 0; marmed = 0; mgo = 0; mirq = 0;
  endfunction

  function automatic void model_step();
    int p, tk, pn, wrap;
    bit gn;
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; model_reset(); return;
    end
    if (!ms2) model_reset();
    else begin
      p    = (period == 0) ? 1 : int'(period);
      tk   = (mcnt >= p - 1) ? 1 : 0;
      pn   = (mpos + tk) % 2048;
      wrap = (tk == 1 && mpos == 2047) ? 1 : 0;
      gn   = 0;
      if (start) begin
        mtgt = int'(target);
        if (pn == mtgt) begin gn = 1; marmed = 0; end
        else marmed = 1;
      end else if (marmed && pn == mtgt) begin
        gn = 1; marmed = 0;
      end
      if (!pcie)      mirq = 0;
      else if (wrap)  mirq = 1;
      else if (ack)   mirq = 0;
      mcnt = tk ? 0 : mcnt + 1;
      mpos = pn;
      mgo  = gn;
    end
    ms2 = ms1; ms1 = 1;
  endfunction

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 pos", int'(pos_o), mpos);
    chk("R3 photocell", int'(photocell_o), (mpos < 6) ? 1 : 0);
    chk("R4 match", int'(match_o), (int'(target) == mpos) ? 1 : 0);
    chk("R5 go", int'(go_o), int'(mgo));
    chk("R7 irq", int'(index_irq_o), int'(mirq));
    start = 1'b0;
    ack   = 1'b0;
  endtask

  task automatic wait_go(output int n);
    n = 0;
    while (!go_o && n < 8000) begin cyc(); n++; end
  endtask

  initial begin
    int n, p0, b;
    void'($urandom(32'd20240611));
    model_reset(); ms1 = 0; ms2 = 0;
    @(negedge clk);
    repeat (3) cyc();
    // R1: reset state while held
    chk("R1 pos", int'(pos_o), 0);
    chk("R1 go", int'(go_o), 0);
    chk("R1 irq", int'(index_irq_o), 0);
    chk("R1 photocell", int'(photocell_o), 1);
    rst_n = 1'b1;
    cyc(); cyc();
    chk("R1 pos after release", int'(pos_o), 0);

    // R2: a period of zero behaves as one
    period = 24'd0;
    p0 = int'(pos_o);
    repeat (10) cyc();
    chk("R2 zero period", (int'(pos_o) - p0 + 2048) % 2048, 10);

    // R5: one word behind the head with P=1 waits 2047 words
    period = 24'd1;
    target = pos_o;
    start = 1'b1;
    cyc();
    wait_go(n);
    chk("R5 full lap words", n, 2047);

    // R5: target equal to the position after the strobe edge fires next cycle
    period = 24'd50;
    while (mcnt != 5) cyc();
    target = pos_o;
    start = 1'b1;
    cyc();
    chk("R5 immediate go", int'(go_o), 1);
    // R5: target input moving while pending is ignored
    target = 11'((int'(pos_o) + 3) % 2048);
    b = int'(target);
    start = 1'b1;
    cyc();
    target = 11'((b + 700) % 2048);
    wait_go(n);
    chk("R5 latched target", int'(pos_o), b);

    // R6: re-arm replaces the pending target
    period = 24'd2;
    target = 11'((int'(pos_o) + 1000) % 2048);
    start = 1'b1;
    cyc();
    repeat (10) cyc();
    b = (int'(pos_o) + 300) % 2048;
    target = 11'(b);
    start = 1'b1;
    cyc();
    wait_go(n);
    chk("R6 replaced target", int'(pos_o), b);

    // R7/R8: index interrupt held until acknowledged
    period = 24'd1;
    pcie = 1'b1;
    n = 0;
    while (!index_irq_o && n < 3000) begin cyc(); n++; end
    chk("R7 irq raised", int'(index_irq_o), 1);
    chk("R7 irq at zero", int'(pos_o), 0);
    repeat (50) cyc();
    chk("R8 irq held", int'(index_irq_o), 1);
    ack = 1'b1;
    cyc();
    chk("R8 irq acked", int'(index_irq_o), 0);
    // R8: acknowledge on the wrap edge loses to the new event
    while (pos_o != 11'd2047) cyc();
    ack = 1'b1;
    cyc();
    chk("R8 set beats ack", int'(index_irq_o), 1);

    // R9: dropping the enable cancels and blocks
    pcie = 1'b0;
    cyc();
    chk("R9 cancelled", int'(index_irq_o), 0);
    repeat (2100) cyc();
    chk("R9 no irq over a lap", int'(index_irq_o), 0);

    // R2: lowering the period mid-word
    period = 24'd40;
    while (mcnt != 20) cyc();
    p0 = int'(pos_o);
    period = 24'd3;
    cyc();
    chk("R2 shortened word", int'(pos_o), (p0 + 1) % 2048);

    // random mix
    period = 24'd1;
    for (int i = 0; i < 26000; i++) begin
      target = 11'($urandom_range(0, 2047));
      if ($urandom_range(0, 299) == 0) start = 1'b1;
      if ($urandom_range(0, 49) == 0) ack = 1'b1;
      if ($urandom_range(0, 1999) == 0) pcie = ~pcie;
      if ($urandom_range(0, 2999) == 0) period = 24'($urandom_range(0, 4));
      cyc();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule